// File: doc/BRIEF.md
# Pipeline Bottleneck Sampling Profiler

The profiler watches eight pipeline-stage busy lines across a run of equal-length sampling windows. Inside each window it counts, for every stage, the cycles in which that stage's busy line was high. When the window closes it gives one credit to the stage that was busy longest. After a run, each stage's 16-bit tally is the number of windows in which that stage was the main bottleneck.

Software drives the block through a small register bus with three locations. Address 0 starts and stops a run and reports whether one is in progress. Address 1 holds the run configuration. Address 2 is a result port: four reads in a row return the eight tallies, packed two per word. A run either records a fixed number of windows or, when the window count is zero, runs until software takes its first result read.

Top module: `bneck_profiler`

## Requirements
- R1: A bus write to address 0 with bit 0 set starts a run. It clears all eight tallies, the window total and the result read pointer. Bit 0 of a read at address 0 and the `run_active` output both show 1 while a run is in progress. Both are 0 after reset.
- R2: Address 1 is a read/write config word. Bits [15:0] hold the window count and bits [31:16] hold the window length in cycles minus one. The config is captured when a run starts.
- R3: Every completed window credits exactly one stage, so the sum of the tallies always equals the number of windows recorded.
- R4: The credited stage is the one whose busy input was high on the most cycles of the window. A tie goes to the lowest stage index, and a window with no busy cycles credits stage 0.
- R5: When the window length is one or two cycles (length field below 2), stage 0 is always credited, whatever the busy inputs do.
- R6: With a nonzero window count N, the run ends by itself on the cycle its N-th window completes.
- R7: A window count of 0 runs continuously until the first read at address 2. That read ends the run, and a window that completes on the same cycle as that read is still credited.
- R8: When the window total passes 0xFFFF, the total and all tallies clear to zero together, and counting goes on from there.
- R9: A read at address 2 returns word k = {tally[2k+1], tally[2k]}, with the lower stage in bits [15:0]. Each read advances k, and k wraps from 3 to 0.
- R10: A result read during a fixed-count run returns the tallies as they stand at that moment. The run keeps going.
- R11: A write to address 0 with bit 0 clear aborts a run in progress. The tallies then stay frozen for readout.
- R12: Read data is registered: `bus_rdata` shows the addressed value on the cycle after the read is issued and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address (0 control, 1 config, 2 results) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| stage_busy | input | 8 | Busy line of each pipeline stage, bit i is stage i |
| run_active | output | 1 | High while a run is in progress |

## Verification
The assertions assume that the bus issues at most one strobe per cycle. They also assume that a run is started only after its configuration word has been written. The bench keeps to both rules: every bus access is a single one-cycle strobe driven on the falling edge, and each config write comes ahead of its start write. The busy inputs are held constant for the whole of each run. This makes the winning stage and the exact window boundaries computable from the start cycle alone, so that reads and aborts can be placed on cycles that are known not to coincide with a window end, except where the overlap is the case under test.

// File: rtl/bnp_pkg.sv
package bnp_pkg;
  localparam int unsigned BNP_STAGES = 8;
  localparam int unsigned BNP_TALLY_W = 16;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_CFG    = 2'd1,
    REG_RESULT = 2'd2
  } bnp_reg_e;
endpackage

// File: rtl/bnp_window_timer.sv
module bnp_window_timer #(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          run,
  input  logic [TW-1:0] len_m1,
  output logic          win_end,
  output logic          short_win
);
  logic [TW-1:0] cyc_q;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      cyc_q <= '0;
    end else if (run) begin
      if (cyc_q == len_m1) cyc_q <= '0;
      else                 cyc_q <= cyc_q + TW'(1);
    end
  end

  assign win_end   = run && (cyc_q == len_m1);
  assign short_win = (len_m1 < TW'(2));

  AST_CYC_BOUND: assert property (@(posedge clk) disable iff (rst || start)
    run |-> (cyc_q <= len_m1)); // R2
endmodule

// File: rtl/bnp_stage_arbiter.sv
module bnp_stage_arbiter #(
  parameter int unsigned NSTAGE = 8,
  parameter int unsigned TW     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              run,
  input  logic              win_go,
  input  logic              short_win,
  input  logic [NSTAGE-1:0] busy,
  output logic [NSTAGE-1:0] grant
);
  localparam int unsigned CW = TW + 1;
  localparam int unsigned SW = $clog2(NSTAGE);

  logic [CW-1:0] cnt_q [NSTAGE];
  logic [CW-1:0] eff   [NSTAGE];
  logic [SW-1:0] best_idx;
  logic [CW-1:0] best_val;
  logic [NSTAGE-1:0] pick;

  for (genvar i = 0; i < NSTAGE; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst || start || win_go) cnt_q[i] <= '0;
      else if (run && busy[i])    cnt_q[i] <= cnt_q[i] + CW'(1);
    end
    assign eff[i] = cnt_q[i] + CW'(busy[i]);
  end

  always_comb begin
    best_idx = '0;
    best_val = eff[0];
    for (int i = 1; i < NSTAGE; i++) begin
      if (eff[i] > best_val) begin
        best_val = eff[i];
        best_idx = SW'(i);
      end
    end
    for (int i = 0; i < NSTAGE; i++) pick[i] = (best_idx == SW'(i));
  end

  assign grant = !win_go ? '0 : (short_win ? NSTAGE'(1) : pick);

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    win_go |-> $onehot(grant)); // R3
  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
    !win_go |-> (grant == '0)); // R3
  AST_SHORT_STAGE0: assert property (@(posedge clk) disable iff (rst)
    (win_go && short_win) |-> grant[0]); // R5
endmodule

// File: rtl/bnp_tally_bank.sv
module bnp_tally_bank #(
  parameter int unsigned NSTAGE = 8,
  parameter int unsigned TW     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [NSTAGE-1:0] grant,
  input  logic              rd_adv,
  output logic [TW-1:0]     total,
  output logic [2*TW-1:0]   rd_word
);
  localparam int unsigned NW   = NSTAGE / 2;
  localparam int unsigned PW   = $clog2(NW);
  localparam int unsigned SUMW = TW + $clog2(NSTAGE);

  logic [TW-1:0]   tally_q [NSTAGE];
  logic [TW-1:0]   total_q;
  logic [PW-1:0]   ptr_q;
  logic [2*TW-1:0] words   [NW];
  logic            credit;
  logic            wrap;

  assign credit = |grant;
  assign wrap   = credit && (total_q == {TW{1'b1}});

  always_ff @(posedge clk) begin
    if (rst || clr)  total_q <= '0;
    else if (credit) total_q <= total_q + TW'(1);
  end

  for (genvar i = 0; i < NSTAGE; i++) begin : g_tally
    always_ff @(posedge clk) begin
      if (rst || clr || wrap) tally_q[i] <= '0;
      else if (grant[i])      tally_q[i] <= tally_q[i] + TW'(1);
    end
  end

  for (genvar w = 0; w < NW; w++) begin : g_word
    assign words[w] = {tally_q[2*w+1], tally_q[2*w]};
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  ptr_q <= '0;
    else if (rd_adv) ptr_q <= ptr_q + PW'(1);
  end

  assign total   = total_q;
  assign rd_word = words[ptr_q];

  logic [SUMW-1:0] tsum;
  always_comb begin
    tsum = '0;
    for (int i = 0; i < NSTAGE; i++) tsum = tsum + SUMW'(tally_q[i]);
  end

  AST_SUM_TOTAL: assert property (@(posedge clk) disable iff (rst)
    tsum == SUMW'(total_q)); // R3
  AST_WRAP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wrap && !clr) |=> (total_q == '0)); // R8
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (rd_adv && !clr) |=> (ptr_q == $past(ptr_q) + PW'(1))); // R9
endmodule

// File: rtl/bneck_profiler.sv
module bneck_profiler
  import bnp_pkg::*;
#(
  parameter int unsigned NSTAGE = BNP_STAGES,
  parameter int unsigned TW     = BNP_TALLY_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [2*TW-1:0]   bus_wdata,
  output logic [2*TW-1:0]   bus_rdata,
  input  logic [NSTAGE-1:0] stage_busy,
  output logic              run_active
);
  localparam int unsigned DW = 2 * TW;

  logic [DW-1:0] cfg_q;
  logic [TW-1:0] tgt_q, len_m1_q;
  logic          run_q;
  logic          start, stop_wr, res_rd;
  logic          win_end, win_go, short_win;
  logic          fix_done, cont_done;
  logic [NSTAGE-1:0] grant;
  logic [TW-1:0] total;
  logic [DW-1:0] rd_word;

  assign start   = bus_wr && (bus_addr == REG_CTRL) &&  bus_wdata[0];
  assign stop_wr = bus_wr && (bus_addr == REG_CTRL) && !bus_wdata[0];
  assign res_rd  = bus_rd && (bus_addr == REG_RESULT);
  assign win_go  = win_end && !start;

  assign fix_done  = win_go && (tgt_q != '0) && ((total + TW'(1)) == tgt_q);
  assign cont_done = run_q && (tgt_q == '0) && res_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      tgt_q    <= '0;
      len_m1_q <= '0;
      run_q    <= 1'b0;
    end else begin
      if (bus_wr && (bus_addr == REG_CFG)) cfg_q <= bus_wdata;
      if (start) begin
        tgt_q    <= cfg_q[TW-1:0];
        len_m1_q <= cfg_q[DW-1:TW];
        run_q    <= 1'b1;
      end else if (stop_wr || fix_done || cont_done) begin
        run_q    <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        REG_CTRL:   bus_rdata <= DW'(run_q);
        REG_CFG:    bus_rdata <= cfg_q;
        REG_RESULT: bus_rdata <= rd_word;
        default:    bus_rdata <= '0;
      endcase
    end
  end

  assign run_active = run_q;

  bnp_window_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .start(start), .run(run_q),
    .len_m1(len_m1_q), .win_end(win_end), .short_win(short_win)
  );

  bnp_stage_arbiter #(.NSTAGE(NSTAGE), .TW(TW)) u_arb (
    .clk(clk), .rst(rst), .start(start), .run(run_q), .win_go(win_go),
    .short_win(short_win), .busy(stage_busy), .grant(grant)
  );

  bnp_tally_bank #(.NSTAGE(NSTAGE), .TW(TW)) u_bank (
    .clk(clk), .rst(rst), .clr(start), .grant(grant), .rd_adv(res_rd),
    .total(total), .rd_word(rd_word)
  );

  AST_START_RUNS: assert property (@(posedge clk) disable iff (rst)
    start |=> run_q); // R1
  AST_FIXED_BOUND: assert property (@(posedge clk) disable iff (rst)
    (run_q && tgt_q != '0) |-> (total < tgt_q)); // R6
  AST_ABORT_STOP: assert property (@(posedge clk) disable iff (rst)
    stop_wr |=> !run_q); // R11
  AST_CONT_STOP: assert property (@(posedge clk) disable iff (rst)
    (cont_done && !start) |=> !run_q); // R7
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R12
endmodule

// File: tb/bneck_profiler_tb.sv
module bneck_profiler_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  stage_busy = '0;
  logic        run_active;

  int n_tests = 0;
  int n_fail  = 0;
  bit ended   = 1'b0;

  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_seen = 1'b0;

  always #5 clk = ~clk;

  bneck_profiler u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .stage_busy(stage_busy), .run_active(run_active)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // monitor: result read issued at a posedge is compared on the following negedge (R12)
  always @(posedge clk) rd_seen <= bus_rd && (bus_addr == 2'd2);
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R9: unexpected result word %h expected none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: pushes expected word, then issues the read
  task automatic rd_res(input string tag, input logic [31:0] exp);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_rd = 1'b1; bus_addr = 2'd2;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_reg(input string tag, input logic [1:0] a, input logic [31:0] exp);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    check(tag, bus_rdata, exp);
  endtask

  task automatic wait_idle(input int limit);
    for (int i = 0; i < limit; i++) begin
      if (!run_active) break;
      @(negedge clk);
    end
    check("R6 run ended", {31'b0, run_active}, 32'd0);
  endtask

  task automatic fixed_run(input logic [7:0] busy, input logic [15:0] lm1, input logic [15:0] n);
    stage_busy = busy;
    wr(2'd1, {lm1, n});
    wr(2'd0, 32'd1);
    wait_idle(4000);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset run_active", {31'b0, run_active}, 32'd0);
    check("R12 reset rdata", bus_rdata, 32'd0);
    rd_reg("R1 reset status", 2'd0, 32'd0);
    for (int k = 0; k < 4; k++) rd_res("R9 reset word", 32'd0);

    // R2 config readback
    wr(2'd1, 32'h0003_0005);
    rd_reg("R2 config readback", 2'd1, 32'h0003_0005);

    // R4/R6: stage 6 only busy, 5 windows of 4 cycles
    fixed_run(8'h40, 16'd3, 16'd5);
    rd_res("R9 w0", 32'd0); rd_res("R9 w1", 32'd0); rd_res("R9 w2", 32'd0);
    rd_res("R4 stage6 wins", 32'h0000_0005);

    // R4 tie between stages 2 and 5 -> stage 2
    fixed_run(8'h24, 16'd5, 16'd3);
    rd_res("R4 tie w0", 32'd0);
    rd_res("R4 tie lowest", 32'h0000_0003);
    rd_res("R4 tie w2", 32'd0); rd_res("R4 tie w3", 32'd0);

    // R4 no busy -> stage 0; leave pointer mid-way, R1 restart clears it
    fixed_run(8'h00, 16'd4, 16'd4);
    rd_res("R4 idle stage0", 32'h0000_0004);

    // R5 short window ignores busy
    fixed_run(8'h80, 16'd1, 16'd7);
    rd_res("R1 ptr cleared / R5 stage0", 32'h0000_0007);
    rd_res("R5 w1", 32'd0); rd_res("R5 w2", 32'd0);
    rd_res("R5 stage7 not credited", 32'd0);

    // R11 abort after 35 cycles of 10-cycle windows -> 3 credits
    stage_busy = 8'h40;
    wr(2'd1, {16'd9, 16'd1000});
    wr(2'd0, 32'd1);
    repeat (34) @(negedge clk);
    wr(2'd0, 32'd0);
    check("R11 aborted", {31'b0, run_active}, 32'd0);
    repeat (50) @(negedge clk);
    rd_res("R11 w0", 32'd0); rd_res("R11 w1", 32'd0); rd_res("R11 w2", 32'd0);
    rd_res("R11 frozen", 32'h0000_0003);

    // R10 partial read during fixed run
    stage_busy = 8'h02;
    wr(2'd1, {16'd9, 16'd20});
    wr(2'd0, 32'd1);
    repeat (24) @(negedge clk);
    rd_res("R10 partial", 32'h0002_0000);
    check("R10 still running", {31'b0, run_active}, 32'd1);
    wait_idle(400);
    rd_res("R9 w1 after partial", 32'd0); rd_res("R9 w2", 32'd0); rd_res("R9 w3", 32'd0);
    rd_res("R9 wrap to w0", 32'h0014_0000);

    // R7 continuous mode stops on first result read
    stage_busy = 8'h10;
    wr(2'd1, {16'd3, 16'd0});
    wr(2'd0, 32'd1);
    repeat (100) @(negedge clk);
    check("R7 continuous running", {31'b0, run_active}, 32'd1);
    rd_res("R7 first read", 32'd0);
    check("R7 stopped by read", {31'b0, run_active}, 32'd0);
    rd_res("R7 w1", 32'd0);
    rd_res("R7 stage4 tally", 32'h0000_0019);
    rd_res("R7 w3", 32'd0);

    // R8 overflow wrap: one-cycle windows, stage 0 each cycle
    stage_busy = 8'h00;
    wr(2'd1, {16'd0, 16'd0});
    wr(2'd0, 32'd1);
    repeat (65545) @(negedge clk);
    rd_res("R8 after wrap", 32'h0000_0009);
    rd_res("R8 w1", 32'd0); rd_res("R8 w2", 32'd0); rd_res("R8 w3", 32'd0);
    rd_res("R7 same-edge window counted", 32'h0000_000A);
    rd_reg("R1 status idle", 2'd0, 32'd0);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule